// File: doc/BRIEF.md
# LSB-justified stereo serial audio receiver

This block turns a three-wire serial audio stream into parallel stereo samples. The three wires are a bit clock, a word-select line and serial data. Each word is LSB-justified: its final bit is shifted in on the last bit-clock rising edge before word select changes level. Data is two's complement and is sent MSB first. Bits that arrive while word select is high form the left word. Bits that arrive while it is low form the right word.

The three lines are sampled by a system clock that runs at least four times faster than the bit clock. Each line passes through a synchronizer. The bit-clock rising edges and the word-select transitions are detected from the synchronized copies. A shift register keeps the most recent `INPUT_BITS` bits. When a word closes, the upper `SAMPLE_BITS` of that window become the sample, so extra low-order bits of a long word are dropped.

A completed left sample is held until the right word that follows it closes. The two samples then move to the output together, with a one-cycle strobe. This keeps the two channels aligned in time.

Top module: `lsbj_stereo_rx`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `left_o` and `right_o` read zero and `valid_o` is low.
- R2: A bit is taken from `ser_data_i` only on a rising edge of `bit_clk_i`. Bits taken while `word_sel_i` is 1 form the left word. Bits taken while it is 0 form the right word.
- R3: Samples are two's complement and arrive MSB first. With `INPUT_BITS` equal to `SAMPLE_BITS` (16), a slot of 16 or more bits yields the last 16 bits received, the earliest of them being the sample MSB.
- R4: With `INPUT_BITS` greater than `SAMPLE_BITS`, the last `INPUT_BITS` bits of a slot are kept and the upper `SAMPLE_BITS` of them are output. For `INPUT_BITS`=20, a slot word W gives W[19:4].
- R5: A 1-to-0 transition of word select closes a left word. A 0-to-1 transition closes a right word. `valid_o` pulses high for exactly one cycle, a fixed delay after a right word closes that was preceded by a closed left word.
- R6: `left_o` and `right_o` change only in a cycle where `valid_o` is high. A closed left word does not reach `left_o` until its right partner closes.
- R7: After reset, the word that was in progress is discarded. The first word-select transition only arms the receiver. If that discarded word was a left word, the right word that follows gives no strobe.
- R8: Bit-clock and word-select edges are ignored until the synchronizer has refilled after reset (`SYNC_STAGES`+1 cycles). A line that is already high at reset release is therefore not taken as an edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_clk_i | input | 1 | Serial bit clock, asynchronous to `clk` |
| word_sel_i | input | 1 | Word select: 1 = left, 0 = right |
| ser_data_i | input | 1 | Serial data, MSB first, two's complement |
| left_o | output | SAMPLE_BITS | Left sample of the latest pair |
| right_o | output | SAMPLE_BITS | Right sample of the latest pair |
| valid_o | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
The bench drives two instances from the same serial lines. Both use 16-bit samples and `SYNC_STAGES`=2. One has `INPUT_BITS`=16 and the other `INPUT_BITS`=20. Slots of 16, 20 and 24 bits are sent, covering exact-length words, LSB-justified padding above the sample, and truncation of trailing bits (W[15:0] against W[19:4]). A walking-one sweep over every slot bit position and the extreme two's-complement codes give expected values by plain bit slicing. Resets issued partway through a right word and partway through a left word exercise the discard and arming rules.

// File: rtl/lsbj_rx_pkg.sv
package lsbj_rx_pkg;

   // Channel a word belongs to, named after the word-select level that carries it.
   typedef enum logic {
      CH_RIGHT = 1'b0,
      CH_LEFT  = 1'b1
   } chan_e;

   // Events recovered from the synchronized serial lines.
   typedef struct packed {
      logic bck_rise;
      logic ws_rise;
      logic ws_fall;
      logic din;
   } line_evt_t;

endpackage

// File: rtl/lsbj_line_sync.sv
module lsbj_line_sync
   import lsbj_rx_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic      clk,
   input  logic      rst,
   input  logic      bck_i,
   input  logic      ws_i,
   input  logic      din_i,
   output line_evt_t evt_o
);

   localparam int LINES  = 3;
   localparam int FILL_N = STAGES + 1;
   localparam int FILL_W = $clog2(FILL_N + 1);
   localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(FILL_N);

   if (STAGES < 2) begin : g_bad_stages
      $error("lsbj_line_sync: STAGES must be at least 2");
   end

   // Bit order in each stage: {bck, ws, din}.
   logic [LINES-1:0]  chain_q [STAGES];
   logic [LINES-1:0]  tail;
   logic [1:0]        prev_q;      // {bck, ws} one cycle behind the tail
   logic [FILL_W-1:0] fill_q;
   logic              primed;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) begin
            chain_q[i] <= '0;
         end
      end else begin
         chain_q[0] <= {bck_i, ws_i, din_i};
         for (int i = 1; i < STAGES; i++) begin
            chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign tail = chain_q[STAGES-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q <= '0;
         fill_q <= '0;
      end else begin
         prev_q <= tail[2:1];
         if (fill_q != FILL_LAST) begin
            fill_q <= fill_q + 1'b1;
         end
      end
   end

   // No events until the synchronizer holds real line values again.
   assign primed = (fill_q == FILL_LAST);

   always_comb begin
      evt_o.bck_rise = primed &  tail[2] & ~prev_q[1];
      evt_o.ws_rise  = primed &  tail[1] & ~prev_q[0];
      evt_o.ws_fall  = primed & ~tail[1] &  prev_q[0];
      evt_o.din      = tail[0];
   end

endmodule

// File: rtl/lsbj_word_shifter.sv
module lsbj_word_shifter #(
   parameter int INPUT_BITS  = 16,
   parameter int SAMPLE_BITS = 16
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   shift_en,
   input  logic                   bit_i,
   output logic [SAMPLE_BITS-1:0] sample_o
);

   localparam int DROP_BITS = INPUT_BITS - SAMPLE_BITS;

   if (DROP_BITS < 0) begin : g_bad_width
      $error("lsbj_word_shifter: INPUT_BITS must not be below SAMPLE_BITS");
   end

   // Window of the most recent INPUT_BITS bits, newest bit at index 0.
   logic [INPUT_BITS-1:0] win_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         win_q <= '0;
      end else if (shift_en) begin
         win_q <= {win_q[INPUT_BITS-2:0], bit_i};
      end
   end

   if (DROP_BITS == 0) begin : g_exact
      assign sample_o = win_q;
   end else begin : g_truncate
      assign sample_o = win_q[INPUT_BITS-1 -: SAMPLE_BITS];
   end

endmodule

// File: rtl/lsbj_pair_reg.sv
module lsbj_pair_reg
   import lsbj_rx_pkg::*;
#(
   parameter int SAMPLE_BITS = 16
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   word_close,
   input  chan_e                  closed_chan,
   input  logic [SAMPLE_BITS-1:0] sample_i,
   output logic [SAMPLE_BITS-1:0] left_o,
   output logic [SAMPLE_BITS-1:0] right_o,
   output logic                   valid_o
);

   logic                   armed_q;
   logic                   left_have_q;
   logic [SAMPLE_BITS-1:0] left_hold_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         armed_q     <= 1'b0;
         left_have_q <= 1'b0;
         left_hold_q <= '0;
         left_o      <= '0;
         right_o     <= '0;
         valid_o     <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (word_close) begin
            if (!armed_q) begin
               // The word cut by reset is dropped; later words are whole.
               armed_q <= 1'b1;
            end else if (closed_chan == CH_LEFT) begin
               left_hold_q <= sample_i;
               left_have_q <= 1'b1;
            end else if (left_have_q) begin
               left_o      <= left_hold_q;
               right_o     <= sample_i;
               valid_o     <= 1'b1;
               left_have_q <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/lsbj_stereo_rx.sv
module lsbj_stereo_rx
   import lsbj_rx_pkg::*;
#(
   parameter int SAMPLE_BITS = 16,
   parameter int INPUT_BITS  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   bit_clk_i,
   input  logic                   word_sel_i,
   input  logic                   ser_data_i,
   output logic [SAMPLE_BITS-1:0] left_o,
   output logic [SAMPLE_BITS-1:0] right_o,
   output logic                   valid_o
);

   if (SAMPLE_BITS < 2) begin : g_bad_sample
      $error("lsbj_stereo_rx: SAMPLE_BITS must be at least 2");
   end
   if (INPUT_BITS < SAMPLE_BITS || INPUT_BITS > 32) begin : g_bad_input
      $error("lsbj_stereo_rx: INPUT_BITS must lie in SAMPLE_BITS..32");
   end

   line_evt_t              line_evt;
   logic                   word_close;
   chan_e                  closed_chan;
   logic [SAMPLE_BITS-1:0] word_sample;

   lsbj_line_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst   (rst),
      .bck_i (bit_clk_i),
      .ws_i  (word_sel_i),
      .din_i (ser_data_i),
      .evt_o (line_evt)
   );

   lsbj_word_shifter #(
      .INPUT_BITS  (INPUT_BITS),
      .SAMPLE_BITS (SAMPLE_BITS)
   ) u_shift (
      .clk      (clk),
      .rst      (rst),
      .shift_en (line_evt.bck_rise),
      .bit_i    (line_evt.din),
      .sample_o (word_sample)
   );

   // A rising word select ends a right word (low level), a falling one a left word.
   assign word_close  = line_evt.ws_rise | line_evt.ws_fall;
   assign closed_chan = line_evt.ws_rise ? CH_RIGHT : CH_LEFT;

   lsbj_pair_reg #(
      .SAMPLE_BITS (SAMPLE_BITS)
   ) u_pair (
      .clk         (clk),
      .rst         (rst),
      .word_close  (word_close),
      .closed_chan (closed_chan),
      .sample_i    (word_sample),
      .left_o      (left_o),
      .right_o     (right_o),
      .valid_o     (valid_o)
   );

endmodule

// File: rtl/lsbj_stereo_rx_chk.sv
module lsbj_stereo_rx_chk
   import lsbj_rx_pkg::*;
#(
   parameter int SAMPLE_BITS = 16
) (
   input logic                   clk,
   input logic                   rst,
   input logic                   word_close,
   input chan_e                  closed_chan,
   input logic [SAMPLE_BITS-1:0] left_o,
   input logic [SAMPLE_BITS-1:0] right_o,
   input logic                   valid_o
);

   logic rst_seen_q;

   always_ff @(posedge clk) begin
      rst_seen_q <= rst;
   end

   // R1: outputs cleared the cycle after reset is sampled
   always @(posedge clk) begin
      if (rst_seen_q === 1'b1) begin
         a_r1_reset_clear: assert (left_o == '0 && right_o == '0 && valid_o == 1'b0)
            else $error("R1: outputs not cleared by reset");
      end
   end

   // R5: the strobe lasts one cycle
   a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
      valid_o |=> !valid_o);

   // R5: a strobe follows only the close of a right word
   a_r5_after_right: assert property (@(posedge clk) disable iff (rst)
      valid_o |-> $past(word_close && closed_chan == CH_RIGHT));

   // R6: the sample pair holds between strobes
   a_r6_pair_hold: assert property (@(posedge clk) disable iff (rst)
      !valid_o |-> ($stable(left_o) && $stable(right_o)));

endmodule

bind lsbj_stereo_rx lsbj_stereo_rx_chk #(
   .SAMPLE_BITS (SAMPLE_BITS)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .word_close  (word_close),
   .closed_chan (closed_chan),
   .left_o      (left_o),
   .right_o     (right_o),
   .valid_o     (valid_o)
);

// File: tb/lsbj_stereo_rx_bench.sv
module lsbj_stereo_rx_bench;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic bck = 1'b0;
   logic ws  = 1'b0;
   logic din = 1'b0;

   logic [15:0] n_left, n_right, w_left, w_right;
   logic        n_valid, w_valid;

   int n_checks = 0;
   int n_errors = 0;

   int          n_cnt = 0, w_cnt = 0;
   logic [15:0] n_cap_l = '0, n_cap_r = '0, w_cap_l = '0, w_cap_r = '0;

   logic [15:0] exp_nl = '0, exp_nr = '0, exp_wl = '0, exp_wr = '0;
   logic [31:0] seed = 32'h1234_5678;

   always #2 clk = ~clk;   // 250 MHz

   lsbj_stereo_rx #(.SAMPLE_BITS(16), .INPUT_BITS(16), .SYNC_STAGES(2)) u_lsbj_stereo_rx (
      .clk(clk), .rst(rst), .bit_clk_i(bck), .word_sel_i(ws), .ser_data_i(din),
      .left_o(n_left), .right_o(n_right), .valid_o(n_valid));

   lsbj_stereo_rx #(.SAMPLE_BITS(16), .INPUT_BITS(20), .SYNC_STAGES(2)) u_lsbj_stereo_rx_wide (
      .clk(clk), .rst(rst), .bit_clk_i(bck), .word_sel_i(ws), .ser_data_i(din),
      .left_o(w_left), .right_o(w_right), .valid_o(w_valid));

   // Strobe monitors, sampled away from the active edge.
   always @(negedge clk) begin
      if (!rst && n_valid) begin
         n_cnt++; n_cap_l = n_left; n_cap_r = n_right;
      end
      if (!rst && w_valid) begin
         w_cnt++; w_cap_l = w_left; w_cap_r = w_right;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic send_bit(input logic w, input logic d);
      @(negedge clk);
      bck = 1'b0; ws = w; din = d;
      repeat (3) @(negedge clk);
      bck = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   // One left slot, one right slot, then a closing bit with word select high.
   task automatic frame(input logic [23:0] lw, input logic [23:0] rw, input int slot);
      int n0, w0;
      n0 = n_cnt; w0 = w_cnt;
      for (int i = slot - 1; i >= 0; i--) send_bit(1'b1, lw[i]);
      for (int i = slot - 1; i >= 0; i--) begin
         send_bit(1'b0, rw[i]);
         if (i == slot - 3) begin
            check("R6 left held until right closes", {16'h0, n_left}, {16'h0, exp_nl});
            check("R6 no early strobe", n_cnt, n0);
         end
      end
      send_bit(1'b1, 1'b0);
      repeat (10) @(negedge clk);
      exp_nl = lw[15:0]; exp_nr = rw[15:0];
      check("R5 one strobe per pair (narrow)", n_cnt, n0 + 1);
      check("R3 left sample (narrow)", {16'h0, n_cap_l}, {16'h0, exp_nl});
      check("R3 right sample (narrow)", {16'h0, n_cap_r}, {16'h0, exp_nr});
      check("R5 one strobe per pair (wide)", w_cnt, w0 + 1);
      if (slot >= 20) begin
         exp_wl = lw[19:4]; exp_wr = rw[19:4];
         check("R4 left truncated (wide)", {16'h0, w_cap_l}, {16'h0, exp_wl});
         check("R4 right truncated (wide)", {16'h0, w_cap_r}, {16'h0, exp_wr});
      end
   endtask

   function automatic logic [31:0] next_rand(input logic [31:0] s);
      return s * 32'd1103515245 + 32'd12345;
   endfunction

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int n0, w0;
      repeat (5) @(negedge clk);
      // R1: reset state
      check("R1 reset left", {16'h0, n_left}, 32'h0);
      check("R1 reset right", {16'h0, n_right}, 32'h0);
      check("R1 reset strobe", {31'h0, n_valid}, 32'h0);
      rst = 1'b0;

      // R7: partial right word after reset is discarded; the next pair is whole
      for (int i = 0; i < 5; i++) send_bit(1'b0, 1'b1);
      frame(24'h0A5C3, 24'h5F00F, 20);

      // R2/R4: walking one over every slot position
      for (int b = 0; b < 20; b++) begin
         frame(24'h1 << b, ~(24'h1 << b) & 24'hFFFFF, 20);
      end

      // R3: extreme two's-complement codes in 24-bit slots
      frame(24'h000000, 24'hFFFFFF, 24);
      frame(24'h800000, 24'h7FFFFF, 24);
      frame(24'hFF8000, 24'h007FFF, 24);   // sign-extended 16-bit min/max

      for (int k = 0; k < 24; k++) begin
         logic [23:0] a, c;
         seed = next_rand(seed); a = seed[27:4];
         seed = next_rand(seed); c = seed[27:4];
         frame(a, c, (k % 3 == 0) ? 16 : ((k % 3 == 1) ? 20 : 24));
      end

      // R8/R7: reset in the middle of a left word
      for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b1);
      @(negedge clk); rst = 1'b1;
      repeat (3) @(negedge clk); rst = 1'b0;
      @(negedge clk);
      check("R1 mid-stream reset left", {16'h0, n_left}, 32'h0);
      check("R1 mid-stream reset right", {16'h0, w_right}, 32'h0);
      exp_nl = '0; exp_nr = '0;
      n0 = n_cnt; w0 = w_cnt;
      for (int i = 0; i < 6; i++) send_bit(1'b1, 1'b0);
      for (int i = 0; i < 20; i++) send_bit(1'b0, i[0]);
      send_bit(1'b1, 1'b0);
      repeat (10) @(negedge clk);
      check("R7 cut left word gives no pair (narrow)", n_cnt, n0);
      check("R8 level high at release not an edge (wide)", w_cnt, w0);
      check("R7 outputs untouched", {16'h0, n_right}, 32'h0);

      frame(24'h0C0DE, 24'h0BEEF, 20);
      frame(24'hF1234, 24'h0FEDC, 20);

      finish_run();
   end

endmodule